// File: doc/BRIEF.md
# Interleaved Dual-Converter Sample Sequencer

This block drives two identical sampling converters so that their combined output runs at twice the rate of either one. Each conversion period it sends a start pulse to converter A. Half a period later it sends a start pulse to converter B. Converter A therefore supplies the even-numbered samples of the merged stream and converter B supplies the odd-numbered ones. The period is set in clock cycles.

When a converter reports completion, the block takes its 12-bit result. Once a B result completes the pair that an A result opened, the block places both samples in one 32-bit word and presents it on a valid/ready output. A single word read therefore returns both samples of the pair. The later sample (B) sits in the upper halfword and the earlier sample (A) in the lower halfword, so reading the word as two halfwords from the top gives the odd sample first.

Sequencing starts only on a trigger event, and only while the enable bit and the continuous-conversion bit are both set. The trigger comes from either an external edge or a software pulse. Clearing either bit stops the start pulses and throws away any pair that is only half done.

Top module: `interleave_seq`

## Requirements
- R1: No start pulse is issued unless both `cfgEnable` and `cfgContinuous` are 1 and a trigger event has been seen since they became 1. At reset both start outputs, `outValid` and `overrun` are 0.
- R2: `cfgTrigSel` selects the trigger source. When it is 0, only a rising edge on `extTrig` is a trigger. When it is 1, only a cycle with `swStart` high is a trigger. The source that is not selected has no effect.
- R3: Raising `cfgEnable` while already configured does not start conversion, and a trigger that arrives while sequencing is running does not restart the phase.
- R4: `convAStart` pulses for one cycle, first in the cycle after the triggering clock edge and then every `cfgPeriod` cycles.
- R5: Each `convBStart` pulse comes exactly floor(`cfgPeriod`/2) cycles after the preceding `convAStart` pulse (for `cfgPeriod` of 2 or more).
- R6: A packed word carries the B sample in bits [27:16] and the A sample in bits [11:0]. Bits [31:28] and [15:12] are 0.
- R7: `outValid` rises only in the cycle after a B completion that follows an A completion of the same run. It then holds with stable data until `outReady` is seen high.
- R8: If a pair completes while `outValid` is 1 and `outReady` is 0, `overrun` becomes 1 and stays 1 until reset, and the new word replaces the old one.
- R9: If the enable or continuous bit drops, no start pulse occurs from the next cycle on. Completions that arrive while stopped are ignored, so a half-finished pair never produces a word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgEnable | input | 1 | Block enable bit |
| cfgContinuous | input | 1 | Continuous conversion mode bit |
| cfgTrigSel | input | 1 | Trigger source: 0 external edge, 1 software pulse |
| swStart | input | 1 | Software trigger pulse |
| extTrig | input | 1 | External trigger level (rising edge used) |
| cfgPeriod | input | PERIOD_W | Conversion period in clock cycles |
| convAStart | output | 1 | Start pulse to converter A |
| convADone | input | 1 | Converter A completion strobe |
| convAData | input | SAMPLE_W | Converter A result |
| convBStart | output | 1 | Start pulse to converter B |
| convBDone | input | 1 | Converter B completion strobe |
| convBData | input | SAMPLE_W | Converter B result |
| outValid | output | 1 | Packed word available |
| outReady | input | 1 | Consumer accepts the packed word |
| outData | output | WORD_W | Packed pair word |
| overrun | output | 1 | Sticky flag: a word was replaced before it was accepted |

## Verification
The bench sweeps the period over even and odd values and alternates the trigger source between runs. Off-by-one phase logic would show up as B starts drifting from floor(P/2), and a rounding-up error would fail only on the odd periods. It checks every packed word against the pair the converter stubs actually delivered: swapped halves or a word released after only the A sample would carry stale or misplaced data. Stops are placed both at arbitrary points and just after a B start. A design that ignored the stop for a cycle too long, or that paired a late B result from a dead run, would emit extra start pulses or a spurious word. A back-pressure case holds the output unaccepted across two pairs and requires the flag to set, stay set, and the latest word to win.

// File: rtl/interleave_seq_pkg.sv
package interleave_seq_pkg;

  typedef enum logic {
    TRIG_EXT = 1'b0,
    TRIG_SW  = 1'b1
  } trigSrcT;

  typedef struct packed {
    logic captureA;
    logic pairDone;
    logic flush;
  } seqStrobeT;

endpackage

// File: rtl/interleave_seq_ctrl.sv
module interleave_seq_ctrl
  import interleave_seq_pkg::*;
#(
  parameter int PERIOD_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgEnable,
  input  logic                cfgContinuous,
  input  logic                cfgTrigSel,
  input  logic                swStart,
  input  logic                extTrig,
  input  logic [PERIOD_W-1:0] cfgPeriod,
  input  logic                convADone,
  input  logic                convBDone,
  output logic                startA,
  output logic                startB,
  output seqStrobeT           strobe
);

  localparam int CNT_W = PERIOD_W + 1;

  logic                running;
  logic                extPrev;
  logic [PERIOD_W-1:0] phaseCnt;
  logic [PERIOD_W-1:0] halfPoint;
  logic                armed;
  logic                trigRise;
  logic                trigEvent;
  logic                lastCount;

  assign armed     = cfgEnable && cfgContinuous;
  assign trigRise  = extTrig && !extPrev;
  assign trigEvent = (trigSrcT'(cfgTrigSel) == TRIG_SW) ? swStart : trigRise;
  assign halfPoint = cfgPeriod >> 1;
  assign lastCount = ({1'b0, phaseCnt} + CNT_W'(1)) >= {1'b0, cfgPeriod};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running  <= 1'b0;
      extPrev  <= 1'b0;
      phaseCnt <= '0;
    end else begin
      extPrev <= extTrig;
      if (!armed) begin
        running  <= 1'b0;
        phaseCnt <= '0;
      end else if (!running) begin
        if (trigEvent) begin
          running  <= 1'b1;
          phaseCnt <= '0;
        end
      end else if (lastCount) begin
        phaseCnt <= '0;
      end else begin
        phaseCnt <= phaseCnt + 1'b1;
      end
    end
  end

  assign startA = running && (phaseCnt == '0);
  assign startB = running && (phaseCnt == halfPoint);

  always_comb begin
    strobe.captureA = running && convADone;
    strobe.pairDone = running && convBDone;
    strobe.flush    = !running;
  end

  // R9: dropping the configuration silences both starts next cycle
  a_r9_stop_next_cycle: assert property (@(posedge clk) disable iff (!rstN)
    !armed |=> (!startA && !startB));

  // R1: from idle, no trigger means no A start in the following cycle
  a_r1_needs_trigger: assert property (@(posedge clk) disable iff (!rstN)
    (!running && !trigEvent) |=> !startA);

  // R4: the first cycle of a run carries the A start
  a_r4_first_start: assert property (@(posedge clk) disable iff (!rstN)
    $rose(running) |-> startA);

  // R4: A start lasts one cycle when the period exceeds one
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (startA && cfgPeriod >= 2 && $stable(cfgPeriod) && armed) |=> !startA);

endmodule

// File: rtl/interleave_seq_datapath.sv
module interleave_seq_datapath
  import interleave_seq_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int WORD_W   = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  seqStrobeT           strobe,
  input  logic [SAMPLE_W-1:0] convAData,
  input  logic [SAMPLE_W-1:0] convBData,
  input  logic                outReady,
  output logic                outValid,
  output logic [WORD_W-1:0]   outData,
  output logic                overrun
);

  localparam int HALF_W = WORD_W / 2;

  logic                haveA;
  logic [SAMPLE_W-1:0] aHold;
  logic                pack;
  logic [WORD_W-1:0]   packedWord;

  assign pack = strobe.pairDone && haveA;

  always_comb begin
    packedWord = '0;
    packedWord[SAMPLE_W-1:0]        = aHold;
    packedWord[HALF_W +: SAMPLE_W]  = convBData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      haveA <= 1'b0;
      aHold <= '0;
    end else if (strobe.flush) begin
      haveA <= 1'b0;
    end else if (strobe.captureA) begin
      haveA <= 1'b1;
      aHold <= convAData;
    end else if (pack) begin
      haveA <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outData  <= '0;
      overrun  <= 1'b0;
    end else if (pack) begin
      outValid <= 1'b1;
      outData  <= packedWord;
      if (outValid && !outReady) overrun <= 1'b1;
    end else if (outValid && outReady) begin
      outValid <= 1'b0;
    end
  end

  // R7: an unaccepted word holds with stable contents
  a_r7_hold_word: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady && !strobe.pairDone) |=> (outValid && $stable(outData)));

  // R7: a word only appears right after a B completion
  a_r7_needs_pair: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) |-> $past(strobe.pairDone));

  // R8: overrun never clears once set
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rstN)
    overrun |=> overrun);

  // R8: a completed pair over a pending word raises overrun
  a_r8_set_on_replace: assert property (@(posedge clk) disable iff (!rstN)
    (pack && outValid && !outReady) |=> overrun);

endmodule

// File: rtl/interleave_seq.sv
module interleave_seq
  import interleave_seq_pkg::*;
#(
  parameter int PERIOD_W = 8,
  parameter int SAMPLE_W = 12,
  parameter int WORD_W   = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgEnable,
  input  logic                cfgContinuous,
  input  logic                cfgTrigSel,
  input  logic                swStart,
  input  logic                extTrig,
  input  logic [PERIOD_W-1:0] cfgPeriod,
  output logic                convAStart,
  input  logic                convADone,
  input  logic [SAMPLE_W-1:0] convAData,
  output logic                convBStart,
  input  logic                convBDone,
  input  logic [SAMPLE_W-1:0] convBData,
  output logic                outValid,
  input  logic                outReady,
  output logic [WORD_W-1:0]   outData,
  output logic                overrun
);

  seqStrobeT strobe;

  interleave_seq_ctrl #(
    .PERIOD_W(PERIOD_W)
  ) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .cfgEnable    (cfgEnable),
    .cfgContinuous(cfgContinuous),
    .cfgTrigSel   (cfgTrigSel),
    .swStart      (swStart),
    .extTrig      (extTrig),
    .cfgPeriod    (cfgPeriod),
    .convADone    (convADone),
    .convBDone    (convBDone),
    .startA       (convAStart),
    .startB       (convBStart),
    .strobe       (strobe)
  );

  interleave_seq_datapath #(
    .SAMPLE_W(SAMPLE_W),
    .WORD_W  (WORD_W)
  ) u_data (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .convAData(convAData),
    .convBData(convBData),
    .outReady (outReady),
    .outValid (outValid),
    .outData  (outData),
    .overrun  (overrun)
  );

endmodule

// File: tb/interleave_seq_tb.sv
module interleave_seq_tb;

  localparam int PW  = 8;
  localparam int SW  = 12;
  localparam int WW  = 32;
  localparam int LAT = 3;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cfgEnable = 1'b0, cfgContinuous = 1'b0, cfgTrigSel = 1'b0;
  logic          swStart = 1'b0, extTrig = 1'b0;
  logic [PW-1:0] cfgPeriod = 8'd8;
  logic          convAStart, convBStart;
  logic          convADone = 1'b0, convBDone = 1'b0;
  logic [SW-1:0] convAData = '0, convBData = '0;
  logic          outValid, outReady = 1'b1, overrun;
  logic [WW-1:0] outData;

  always #5 clk = ~clk;

  interleave_seq u_dut (
    .clk(clk), .rstN(rstN), .cfgEnable(cfgEnable), .cfgContinuous(cfgContinuous),
    .cfgTrigSel(cfgTrigSel), .swStart(swStart), .extTrig(extTrig), .cfgPeriod(cfgPeriod),
    .convAStart(convAStart), .convADone(convADone), .convAData(convAData),
    .convBStart(convBStart), .convBDone(convBDone), .convBData(convBData),
    .outValid(outValid), .outReady(outReady), .outData(outData), .overrun(overrun)
  );

  int checks = 0, fails = 0;
  int cyc = 0, curP = 8;
  int aStarts = 0, bStarts = 0, pairCount = 0, wordCount = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  function automatic logic [SW-1:0] fA(input int i);
    return SW'((i * 293 + 17) & 12'hFFF);
  endfunction
  function automatic logic [SW-1:0] fB(input int i);
    return SW'((i * 151 + 2000) & 12'hFFF);
  endfunction

  // converter stubs, reference model and monitor share one negedge process
  bit runModel = 0, extPrevM = 0, haveAM = 0, pend = 0, prevValid = 0, aArm = 0;
  int lastACyc = 0, busyA = 0, busyB = 0, idxA = 0, idxB = 0;
  logic [SW-1:0] lastAM = '0;
  logic [WW-1:0] expWord = '0;

  always @(negedge clk) begin
    bit wasPend, trig;
    cyc++;
    if (cyc > 100000) begin
      check(1'b0, "watchdog", cyc, 100000);
      summary();
    end
    wasPend = pend;
    if (pend) begin
      check(outValid == 1'b1, "R7 valid after pair", outValid, 1);
      check(outData == expWord, "R6 packed word", outData, expWord);
      check(outData[31:28] == 4'h0 && outData[15:12] == 4'h0, "R6 zero bits", outData, expWord);
      pend = 0;
    end
    if (outValid && !prevValid && !wasPend)
      check(1'b0, "R7 word without pair", outValid, 0);
    prevValid = outValid;
    if (outValid && outReady) wordCount++;

    if ((convAStart || convBStart) && !runModel)
      check(1'b0, "R1 R9 start while stopped", {convAStart, convBStart}, 0);
    if (!runModel) aArm = 0;
    if (convAStart) begin
      aStarts++;
      if (aArm) check(cyc - lastACyc == curP, "R4 A period", cyc - lastACyc, curP);
      lastACyc = cyc;
      aArm = 1;
    end
    if (convBStart) begin
      bStarts++;
      if (aArm) check(cyc - lastACyc == curP / 2, "R5 B offset", cyc - lastACyc, curP / 2);
    end

    // stubs: done strobes driven now reach the DUT at the next posedge
    convADone = 1'b0;
    convBDone = 1'b0;
    if (busyA > 0) begin
      busyA--;
      if (busyA == 0) begin
        convADone = 1'b1;
        convAData = fA(idxA);
        idxA++;
        if (runModel) begin haveAM = 1; lastAM = convAData; end
      end
    end
    if (busyB > 0) begin
      busyB--;
      if (busyB == 0) begin
        convBDone = 1'b1;
        convBData = fB(idxB);
        idxB++;
        if (runModel && haveAM) begin
          expWord = {4'h0, convBData, 4'h0, lastAM};
          pend = 1;
          pairCount++;
          haveAM = 0;
        end
      end
    end
    if (convAStart) busyA = LAT;
    if (convBStart) busyB = LAT;

    // model the run state the DUT will hold after the next posedge
    trig = cfgTrigSel ? swStart : (extTrig && !extPrevM);
    extPrevM = extTrig;
    runModel = cfgEnable && cfgContinuous && (runModel || trig);
    if (!runModel) haveAM = 0;
  end

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic pulseSw();
    step(); swStart = 1'b1;
    step(); swStart = 1'b0;
  endtask

  task automatic pulseExt();
    step(); extTrig = 1'b1;
    step(); extTrig = 1'b0;
  endtask

  int snapA, snapB, snapW, base;

  initial begin
    repeat (4) step();
    rstN = 1'b1;
    step();
    check(outValid == 0, "R1 reset outValid", outValid, 0);
    check(overrun == 0, "R1 reset overrun", overrun, 0);
    check(!convAStart && !convBStart, "R1 reset starts", {convAStart, convBStart}, 0);

    // R1: continuous mode off, a software trigger does nothing
    cfgEnable = 1; cfgTrigSel = 1; cfgPeriod = 8; curP = 8;
    snapA = aStarts;
    pulseSw();
    repeat (20) step();
    check(aStarts == snapA, "R1 idle without continuous", aStarts, snapA);

    // R3: raising enable alone does not start
    cfgContinuous = 1; cfgEnable = 0;
    step(); cfgEnable = 1;
    repeat (20) step();
    check(aStarts == snapA, "R3 enable is not a trigger", aStarts, snapA);

    // R2: unselected sources are ignored
    cfgTrigSel = 1; pulseExt();
    repeat (10) step();
    check(aStarts == snapA, "R2 ext ignored when sw selected", aStarts, snapA);
    cfgTrigSel = 0; pulseSw();
    repeat (10) step();
    check(aStarts == snapA, "R2 sw ignored when ext selected", aStarts, snapA);

    // sweep of periods, alternating trigger source and stop style
    for (int p = 6; p <= 11; p++) begin
      curP = p; cfgPeriod = PW'(p);
      cfgTrigSel = p[0];
      cfgEnable = 1; cfgContinuous = 1; outReady = 1;
      step();
      base = pairCount;
      if (p[0]) pulseSw(); else pulseExt();
      while (pairCount < base + 2) step();
      pulseSw();  // R3: mid-run trigger must not shift the phase
      pulseExt();
      while (pairCount < base + 4) step();
      repeat (2) step();
      if (!p[0]) begin
        while (!convBStart) step();
        cfgEnable = 0;       // R9: stop with a pair half done
      end else begin
        step();
        cfgContinuous = 0;   // R9: stop at an arbitrary point
      end
      @(negedge clk); #1;
      snapA = aStarts; snapB = bStarts; snapW = wordCount;
      repeat (20) step();
      check(aStarts == snapA && bStarts == snapB, "R9 starts stop next cycle",
            aStarts + bStarts, snapA + snapB);
      check(wordCount == snapW, "R9 half pair discarded", wordCount, snapW);
      check(pairCount >= base + 4, "R4 pairs produced", pairCount, base + 4);
    end

    // R8: overrun under back-pressure
    cfgPeriod = 8; curP = 8; cfgTrigSel = 1; outReady = 0;
    cfgEnable = 1; cfgContinuous = 1;
    step();
    base = pairCount;
    pulseSw();
    while (pairCount < base + 1) step();
    repeat (2) step();
    check(overrun == 0, "R8 no overrun on first word", overrun, 0);
    check(outValid == 1, "R7 word held while not ready", outValid, 1);
    while (pairCount < base + 2) step();
    repeat (2) step();
    check(overrun == 1, "R8 overrun set on replace", overrun, 1);
    check(outData == expWord, "R8 newest word kept", outData, expWord);
    cfgEnable = 0;
    step();
    outReady = 1;
    step(); step();
    check(outValid == 0, "R7 word released on ready", outValid, 0);
    check(overrun == 1, "R8 overrun sticky", overrun, 1);

    summary();
  end

endmodule